// File: doc/BRIEF.md
# Serial Debug Register Access Unit

This unit gives an external debug controller a serial path into the arbiter chip's configuration. A 16-bit address is shifted in one bit per enabled clock while the address-mode input is high. The address splits into a board field (bits 15:12), a hybrid field (11:8), a bus-interface field (7:5), a chip field (4:3) and a path field (2:0). The unit answers only when the board field equals the slot number and bits 11:3 are all zero. The path field then picks one internal register, and the data chain takes the length of that register.

An execute pulse copies the selected register into the data chain, or copies the chain into the register when the write input is high. Data then leaves or enters serially, least significant bit first. For addresses of other devices on the same board, the unit also performs the first-level decode of the hybrid field into an active-low one-hot select.

Top module: `dbg_scan_port`

## Requirements
- R1: While `shift_en` and `addr_mode` are both high, each clock shifts `ser_in` into the address register at bit 15 and moves the other bits one place towards bit 0. After 16 shifts, the first bit sent is address bit 0.
- R2: `bd_sel` is high exactly when address bits 15:12 equal `slot_no`.
- R3: `hyb_sel_n[k]` is low only when `bd_sel` is high, arbiter-configuration bit 3 (decode enable) is 1, and the hybrid field equals k+1. In every other case all five bits are high.
- R4: An execute pulse with `wr` low, at an address selecting this unit, loads the selected register into the data chain. `ser_out` then shows bit 0, and each data shift (`shift_en` high, `addr_mode` low) brings the next bit.
- R5: The paths are as follows. Path 0 is the 16-bit chip ID, read only. Path 1 holds 72 device-config bits, device k at bits 9k+8..9k, read/write. Path 2 holds 4 arbiter-config bits: bits 2:0 are the arbiter number and bit 3 is the decode enable, read/write. Path 3 is the 2-bit board ID `bd_id`, read only.
- R6: For a write, the data bits are shifted in LSB first, one per data shift, for the path's length. An execute pulse with `wr` high then stores them, and `cfg_dev` and `arb_no` show the new value from the next cycle.
- R7: Writes to paths 0 and 3, and to path codes 4 to 7, change no register.
- R8: Path codes 4 to 7 read back as all zeros.
- R9: An execute pulse at an address whose board field differs from `slot_no`, or whose bits 11:3 are not zero, changes no register.
- R10: While `dbg_rst_n` is low, a clock clears the device config, the arbiter config and the address register.
- R11: While `rst_n` is low, all state is cleared: `ser_out` is 0, `cfg_dev` and `arb_no` are 0, and `hyb_sel_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| dbg_rst_n | input | 1 | synchronous active-low debug reset |
| shift_en | input | 1 | one serial shift per clock while high |
| addr_mode | input | 1 | 1 steers shifts into the address register, 0 into the data chain |
| ser_in | input | 1 | serial data in |
| exec | input | 1 | one-cycle execute pulse |
| wr | input | 1 | 1 write, 0 read at execute |
| slot_no | input | 4 | board slot number |
| bd_id | input | 2 | board type and version |
| ser_out | output | 1 | serial data out, bit 0 of the chain |
| bd_sel | output | 1 | board field matches slot |
| hyb_sel_n | output | 5 | active-low hybrid select |
| cfg_dev | output | 72 | device port configuration |
| arb_no | output | 3 | arbiter number |

## Verification
The assertions assume that `exec` is never high in the same cycle as `shift_en`. They also assume that `slot_no` and `bd_id` change only while the port is idle. The stimulus holds every input steady across a clock edge and sets it at the falling edge. It raises `exec` only in a cycle of its own, after the shifting has finished. It sets `slot_no` once after reset and leaves it alone, apart from a single directed mismatch case that changes the address, not the slot.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  localparam int ADDR_W     = 16;
  localparam int BOARD_LSB  = 12;
  localparam int HYB_LSB    = 8;
  localparam int FIELD_W    = 4;
  localparam int PATH_W     = 3;
  localparam int ARB_CFG_W  = 4;
  localparam int ARB_NO_W   = 3;
  localparam int CHIP_ID_W  = 16;
  localparam int BRD_ID_W   = 2;

  localparam logic [PATH_W-1:0] P_CHIP = 3'd0;
  localparam logic [PATH_W-1:0] P_DEV  = 3'd1;
  localparam logic [PATH_W-1:0] P_ARB  = 3'd2;
  localparam logic [PATH_W-1:0] P_BRD  = 3'd3;

  function automatic int path_len(logic [PATH_W-1:0] p, int dev_bits);
    case (p)
      P_CHIP:  return CHIP_ID_W;
      P_DEV:   return dev_bits;
      P_ARB:   return ARB_CFG_W;
      P_BRD:   return BRD_ID_W;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/dbg_addr_unit.sv
module dbg_addr_unit
  import dbg_port_pkg::*;
#(
  parameter int N_HYB = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_rst_n,
  input  logic                 shift,
  input  logic                 ser_in,
  input  logic [FIELD_W-1:0]   slot_no,
  input  logic                 dec_en,
  output logic                 bd_sel,
  output logic                 self_sel,
  output logic [PATH_W-1:0]    path,
  output logic [N_HYB-1:0]     hyb_sel_n
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [FIELD_W-1:0] hyb_f;

  always_comb begin
    addr_d = addr_q;
    if (!dbg_rst_n)  addr_d = '0;
    else if (shift)  addr_d = {ser_in, addr_q[ADDR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign hyb_f    = addr_q[HYB_LSB +: FIELD_W];
  assign bd_sel   = (addr_q[BOARD_LSB +: FIELD_W] == slot_no);
  assign self_sel = bd_sel && (addr_q[BOARD_LSB-1:PATH_W] == '0);
  assign path     = addr_q[PATH_W-1:0];

  for (genvar k = 0; k < N_HYB; k++) begin : g_hyb
    assign hyb_sel_n[k] = !(bd_sel && dec_en && (hyb_f == FIELD_W'(k + 1)));
  end
endmodule

// File: rtl/dbg_chain.sv
module dbg_chain #(
  parameter int W  = 72,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          load,
  input  logic          ser_in,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  ld_data,
  output logic [W-1:0]  chain_q
);
  logic [W-1:0] shifted, chain_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shifted[i] = (len == LW'(i + 1)) ? ser_in : 1'b0;
    end else begin : g_mid
      assign shifted[i] = (len == LW'(i + 1)) ? ser_in :
                          (len >  LW'(i + 1)) ? chain_q[i+1] : 1'b0;
    end
  end

  always_comb begin
    chain_d = chain_q;
    if (load)       chain_d = ld_data;
    else if (shift) chain_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/dbg_cfg_bank.sv
module dbg_cfg_bank
  import dbg_port_pkg::*;
#(
  parameter int                 W       = 72,
  parameter logic [CHIP_ID_W-1:0] CHIP_ID = 16'hA5C3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dbg_rst_n,
  input  logic                  wr_en,
  input  logic [PATH_W-1:0]     path,
  input  logic [W-1:0]          wdata,
  input  logic [BRD_ID_W-1:0]   bd_id,
  output logic [W-1:0]          rdata,
  output logic [W-1:0]          dev_q,
  output logic [ARB_CFG_W-1:0]  arb_q
);
  logic [W-1:0]         dev_d;
  logic [ARB_CFG_W-1:0] arb_d;

  always_comb begin
    dev_d = dev_q;
    arb_d = arb_q;
    if (!dbg_rst_n) begin
      dev_d = '0;
      arb_d = '0;
    end else if (wr_en) begin
      if (path == P_DEV) dev_d = wdata;
      if (path == P_ARB) arb_d = wdata[ARB_CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      arb_q <= '0;
    end else begin
      dev_q <= dev_d;
      arb_q <= arb_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (path)
      P_CHIP:  rdata[CHIP_ID_W-1:0] = CHIP_ID;
      P_DEV:   rdata = dev_q;
      P_ARB:   rdata[ARB_CFG_W-1:0] = arb_q;
      P_BRD:   rdata[BRD_ID_W-1:0] = bd_id;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
  import dbg_port_pkg::*;
#(
  parameter int                   N_DEV     = 8,
  parameter int                   DEV_CFG_W = 9,
  parameter int                   N_HYB     = 5,
  parameter logic [CHIP_ID_W-1:0] CHIP_ID   = 16'hA5C3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dbg_rst_n,
  input  logic                       shift_en,
  input  logic                       addr_mode,
  input  logic                       ser_in,
  input  logic                       exec,
  input  logic                       wr,
  input  logic [3:0]                 slot_no,
  input  logic [1:0]                 bd_id,
  output logic                       ser_out,
  output logic                       bd_sel,
  output logic [N_HYB-1:0]           hyb_sel_n,
  output logic [N_DEV*DEV_CFG_W-1:0] cfg_dev,
  output logic [2:0]                 arb_no
);
  localparam int CW = N_DEV * DEV_CFG_W;
  localparam int LW = $clog2(CW + 1);

  logic                 rs_q1, rs_q2;
  logic                 self_sel;
  logic [PATH_W-1:0]    path;
  logic [ARB_CFG_W-1:0] arb_q;
  logic [CW-1:0]        chain_q, rdata;
  logic [LW-1:0]        len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  assign len = LW'(path_len(path, CW));

  dbg_addr_unit #(.N_HYB(N_HYB)) u_addr (
    .clk(clk), .rst_n(rs_q2), .dbg_rst_n(dbg_rst_n),
    .shift(shift_en && addr_mode && !exec), .ser_in(ser_in),
    .slot_no(slot_no), .dec_en(arb_q[ARB_CFG_W-1]),
    .bd_sel(bd_sel), .self_sel(self_sel), .path(path),
    .hyb_sel_n(hyb_sel_n)
  );

  dbg_chain #(.W(CW), .LW(LW)) u_chain (
    .clk(clk), .rst_n(rs_q2),
    .shift(shift_en && !addr_mode), .load(exec && !wr && self_sel),
    .ser_in(ser_in), .len(len), .ld_data(rdata), .chain_q(chain_q)
  );

  dbg_cfg_bank #(.W(CW), .CHIP_ID(CHIP_ID)) u_cfg (
    .clk(clk), .rst_n(rs_q2), .dbg_rst_n(dbg_rst_n),
    .wr_en(exec && wr && self_sel), .path(path), .wdata(chain_q),
    .bd_id(bd_id), .rdata(rdata), .dev_q(cfg_dev), .arb_q(arb_q)
  );

  assign ser_out = chain_q[0];
  assign arb_no  = arb_q[ARB_NO_W-1:0];
endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk #(
  parameter int CW    = 72,
  parameter int N_HYB = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_rst_n,
  input logic             shift_en,
  input logic             addr_mode,
  input logic             exec,
  input logic             wr,
  input logic [3:0]       slot_no,
  input logic             bd_sel,
  input logic [N_HYB-1:0] hyb_sel_n,
  input logic [CW-1:0]    cfg_dev,
  input logic [2:0]       arb_no
);
  AST_HYB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~hyb_sel_n)); // R3

  AST_HYB_NEEDS_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
    (hyb_sel_n != '1) |-> bd_sel); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(shift_en && addr_mode) && dbg_rst_n) |=> ($stable(bd_sel) || !$stable(slot_no))); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(exec && wr) && dbg_rst_n) |=> ($stable(cfg_dev) && $stable(arb_no))); // R6

  AST_DBG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rst_n |=> (cfg_dev == '0 && arb_no == '0 && hyb_sel_n == '1)); // R10
endmodule

bind dbg_scan_port dbg_scan_port_chk #(.CW(N_DEV*DEV_CFG_W), .N_HYB(N_HYB)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .shift_en(shift_en),
  .addr_mode(addr_mode), .exec(exec), .wr(wr), .slot_no(slot_no),
  .bd_sel(bd_sel), .hyb_sel_n(hyb_sel_n), .cfg_dev(cfg_dev), .arb_no(arb_no)
);

// File: tb/test_dbg_scan_port.sv
module test_dbg_scan_port;
  logic clk = 1'b0;
  logic rst_n, dbg_rst_n, shift_en, addr_mode, ser_in, exec, wr;
  logic [3:0] slot_no;
  logic [1:0] bd_id;
  logic ser_out, bd_sel;
  logic [4:0] hyb_sel_n;
  logic [71:0] cfg_dev;
  logic [2:0] arb_no;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  dbg_scan_port i_dbg_scan_port (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .shift_en(shift_en),
    .addr_mode(addr_mode), .ser_in(ser_in), .exec(exec), .wr(wr),
    .slot_no(slot_no), .bd_id(bd_id), .ser_out(ser_out), .bd_sel(bd_sel),
    .hyb_sel_n(hyb_sel_n), .cfg_dev(cfg_dev), .arb_no(arb_no)
  );

  localparam logic [3:0]  SLOT  = 4'hA;
  localparam logic [71:0] DATA1 = 72'h123456789ABCDEF012;

  typedef struct packed {
    logic [2:0]  path;
    logic        wr;
    logic [6:0]  len;
    logic [71:0] data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 1'b1, 7'd72, DATA1},
    '{3'd1, 1'b0, 7'd72, DATA1},
    '{3'd2, 1'b1, 7'd4,  72'hD},
    '{3'd2, 1'b0, 7'd4,  72'hD},
    '{3'd0, 1'b0, 7'd16, 72'hA5C3},
    '{3'd3, 1'b0, 7'd2,  72'h2},
    '{3'd0, 1'b1, 7'd16, 72'hFFFF},
    '{3'd0, 1'b0, 7'd16, 72'hA5C3},
    '{3'd3, 1'b1, 7'd2,  72'h1},
    '{3'd3, 1'b0, 7'd2,  72'h2},
    '{3'd5, 1'b0, 7'd8,  72'h0},
    '{3'd6, 1'b1, 7'd1,  72'h1},
    '{3'd6, 1'b0, 7'd8,  72'h0},
    '{3'd1, 1'b0, 7'd72, DATA1}
  };

  task automatic check(string req, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_addr(logic [15:0] a);
    for (int i = 0; i < 16; i++) begin
      shift_en = 1'b1; addr_mode = 1'b1; ser_in = a[i];
      @(negedge clk);
    end
    shift_en = 1'b0; addr_mode = 1'b0; ser_in = 1'b0;
  endtask

  task automatic shift_data(logic [71:0] v, int len);
    for (int i = 0; i < len; i++) begin
      shift_en = 1'b1; addr_mode = 1'b0; ser_in = v[i];
      @(negedge clk);
    end
    shift_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic pulse_exec(logic w);
    exec = 1'b1; wr = w;
    @(negedge clk);
    exec = 1'b0; wr = 1'b0;
  endtask

  task automatic read_out(int len, output logic [71:0] v);
    v = '0;
    for (int i = 0; i < len; i++) begin
      v[i] = ser_out;
      shift_en = 1'b1; addr_mode = 1'b0; ser_in = 1'b0;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  function automatic logic [15:0] self_addr(logic [2:0] p);
    return {SLOT, 9'b0, p};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [71:0] rv;
    rst_n = 1'b0; dbg_rst_n = 1'b1; shift_en = 1'b0; addr_mode = 1'b0;
    ser_in = 1'b0; exec = 1'b0; wr = 1'b0; slot_no = SLOT; bd_id = 2'b10;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 ser_out", 72'(ser_out), 72'h0);
    check("R11 cfg_dev", cfg_dev, 72'h0);
    check("R11 arb_no", 72'(arb_no), 72'h0);
    check("R11 hyb_sel_n", 72'(hyb_sel_n), 72'h1F);
    check("R2 bd_sel after reset", 72'(bd_sel), 72'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: address shifted LSB first selects board
    shift_addr(self_addr(3'd0));
    check("R1 R2 bd_sel on match", 72'(bd_sel), 72'h1);

    // table walk: R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      shift_addr(self_addr(TBL[k].path));
      if (TBL[k].wr) begin
        shift_data(TBL[k].data, int'(TBL[k].len));
        pulse_exec(1'b1);
      end else begin
        pulse_exec(1'b0);
        read_out(int'(TBL[k].len), rv);
        check($sformatf("R4 R5 R7 R8 row %0d path %0d", k, TBL[k].path), rv, TBL[k].data);
      end
    end
    check("R6 cfg_dev port", cfg_dev, DATA1);
    check("R6 arb_no port", 72'(arb_no), 72'h5);

    // R3: hybrid decode with decode enable set
    shift_addr({SLOT, 4'd3, 8'h00});
    check("R3 hybrid 3", 72'(hyb_sel_n), 72'h1B);
    shift_addr({SLOT, 4'd5, 8'h00});
    check("R3 hybrid 5", 72'(hyb_sel_n), 72'h0F);
    shift_addr({SLOT, 4'd6, 8'h00});
    check("R3 hybrid 6 out of range", 72'(hyb_sel_n), 72'h1F);
    shift_addr({4'h3, 4'd1, 8'h00});
    check("R2 bd_sel mismatch", 72'(bd_sel), 72'h0);
    check("R3 hybrid on other board", 72'(hyb_sel_n), 72'h1F);

    // R9: execute at non-selecting addresses
    shift_addr({4'h3, 9'b0, 3'd2});
    shift_data(72'h0, 4);
    pulse_exec(1'b1);
    check("R9 board mismatch write", 72'(arb_no), 72'h5);
    shift_addr({SLOT, 4'd1, 5'b0, 3'd2});
    shift_data(72'h0, 4);
    pulse_exec(1'b1);
    check("R9 hybrid nonzero write", 72'(arb_no), 72'h5);

    // R3: decode enable off
    shift_addr(self_addr(3'd2));
    shift_data(72'h6, 4);
    pulse_exec(1'b1);
    check("R6 arb_no rewrite", 72'(arb_no), 72'h6);
    shift_addr({SLOT, 4'd2, 8'h00});
    check("R3 decode disabled", 72'(hyb_sel_n), 72'h1F);

    // R10: debug reset
    shift_addr(self_addr(3'd1));
    dbg_rst_n = 1'b0;
    @(negedge clk);
    dbg_rst_n = 1'b1;
    check("R10 cfg_dev", cfg_dev, 72'h0);
    check("R10 arb_no", 72'(arb_no), 72'h0);
    check("R10 address cleared", 72'(bd_sel), 72'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule